// File: doc/BRIEF.md
# Ring-List Completion Engine

This device-side engine serves a host through two circular lists of programmable depth. The host fills units of an inbound list, each holding a request's physical address and byte size. It posts work by writing the inbound write index with the index of the last unit it filled. The engine walks the inbound list in order, starting after the last unit it consumed. It offers each unit to a local agent over a valid/ready handshake.

When the agent finishes a request, it returns the request's flag word, which carries the request's index. The engine ORs the flag with the host marker 0x40000000, stores the result in the next outbound unit and records that unit's index in a shadow register. It then sets an interrupt cause. The host keeps its own read index N. When the shadow differs from N, the host reads unit N+1, wrapping at the depth.

Commands that bypass the lists use a host-to-device message word. The agent acknowledges such a command, and the engine then copies the same value into the device-to-host message word. The lists are modelled as internal arrays, and the host reads and writes them through the register port.

Top module: `ring_cpl_engine`

## Requirements
- R1: After reset the depth reads 32, the write index and the shadow both read 31, the interrupt cause reads 0, and irq_o and req_valid_o are low.
- R2: A write to register 0 sets the depth. The value is limited to the range 1..32, so 0 reads back as 1 and anything above 32 reads back as 32. The same write sets the write index, the consumed index and the shadow (register 2) all to depth-1, which leaves the inbound list empty.
- R3: Register 7 selects a unit. Writes to registers 8 and 9 set the address and size of the selected inbound unit. The engine offers units in index order, starting after the last consumed one and wrapping from depth-1 to 0. req_valid_o is low whenever the consumed index equals the write index (register 1).
- R4: Only a cycle with req_valid_o and req_ready_i both high consumes a unit. While req_ready_i is low, req_valid_o, req_addr_o and req_size_o hold.
- R5: A cycle with cpl_valid_i high writes cpl_flag_i OR 0x40000000 into the outbound unit after the shadow index, with wrap. From the next cycle the shadow (register 2) reads that index, and register 10 returns the unit selected by register 7.
- R6: Every completion sets bit 0 of the cause register (register 3). Writing 1 to that bit clears it. When a completion and a clear fall in the same cycle, the bit stays set.
- R7: irq_o is high exactly when the cause bit and bit 0 of the enable register (register 4) are both set.
- R8: A write to register 5 raises msg_valid_o with msg_data_o equal to the written value. msg_ack_i drops msg_valid_o, and register 6 then reads the same value.
- R9: A write to register 1 with a value not below the depth is ignored, and the write index keeps its old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we_i | input | 1 | Host register write strobe |
| reg_addr_i | input | 4 | Host register index |
| reg_wdata_i | input | 32 | Host write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| req_valid_o | output | 1 | An inbound unit is offered to the agent |
| req_ready_i | input | 1 | Agent accepts the offered unit |
| req_addr_o | output | 32 | Physical address of the offered request |
| req_size_o | output | 16 | Size of the offered request |
| cpl_valid_i | input | 1 | Agent completes one request this cycle |
| cpl_flag_i | input | 32 | Flag word of the completed request |
| msg_valid_o | output | 1 | Host message waiting for the agent |
| msg_data_o | output | 32 | Host message value |
| msg_ack_i | input | 1 | Agent has finished the message |
| irq_o | output | 1 | Outbound interrupt |

## Verification
The bench makes an agent completion and a host write-1-to-clear of the cause bit fall in the same cycle. It drives cpl_valid_i and the clear write on one clock edge. The cause must then read 1 and irq_o must stay high, because the set has priority over the clear. A clear on its own must drop the bit. Each depth in a sweep then runs several rounds in which postings, consumption and completions wrap around both lists. The shadow and every outbound unit are compared with the index and value that the bench computes.

// File: rtl/rce_pkg.sv
package rce_pkg;

    localparam int WORD_W     = 32;
    localparam int REQ_ADDR_W = 32;
    localparam int REQ_SIZE_W = 16;

    localparam logic [WORD_W-1:0] HOST_MARK = 32'h4000_0000;

    typedef enum logic [3:0] {
        REG_DEPTH     = 4'd0,
        REG_WPTR      = 4'd1,
        REG_SHADOW    = 4'd2,
        REG_CAUSE     = 4'd3,
        REG_ENABLE    = 4'd4,
        REG_MSG_IN    = 4'd5,
        REG_MSG_OUT   = 4'd6,
        REG_UNIT_SEL  = 4'd7,
        REG_UNIT_ADDR = 4'd8,
        REG_UNIT_SIZE = 4'd9,
        REG_OUT_UNIT  = 4'd10
    } reg_id_e;

    typedef struct packed {
        logic [REQ_ADDR_W-1:0] addr;
        logic [REQ_SIZE_W-1:0] size;
    } in_unit_t;

    typedef struct packed {
        logic              we;
        reg_id_e           id;
        logic [WORD_W-1:0] data;
    } host_wr_t;

endpackage

// File: rtl/rce_host_regs.sv
module rce_host_regs
    import rce_pkg::*;
#(
    parameter int MAX_DEPTH = 32,
    parameter int IDX_W     = 5,
    parameter int DEPTH_W   = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  host_wr_t           wr_i,
    input  reg_id_e            rd_id_i,
    output logic [WORD_W-1:0]  rdata_o,
    output logic               reload_o,
    output logic [IDX_W-1:0]   reload_idx_o,
    output logic [IDX_W-1:0]   last_idx_o,
    output logic [IDX_W-1:0]   wptr_o,
    output logic [IDX_W-1:0]   sel_o,
    output logic               in_wr_addr_o,
    output logic               in_wr_size_o,
    input  logic [IDX_W-1:0]   shadow_i,
    input  in_unit_t           in_unit_i,
    input  logic [WORD_W-1:0]  out_unit_i,
    input  logic               cpl_fire_i,
    input  logic               msg_ack_i,
    output logic               msg_valid_o,
    output logic [WORD_W-1:0]  msg_data_o,
    output logic [WORD_W-1:0]  msg_out_o,
    output logic               int_en_o,
    output logic               irq_o
);

    localparam logic [DEPTH_W-1:0] DEPTH_MAX = DEPTH_W'(MAX_DEPTH);
    localparam logic [IDX_W-1:0]   IDX_LAST  = IDX_W'(MAX_DEPTH - 1);

    logic [DEPTH_W-1:0] depth_q;
    logic [DEPTH_W-1:0] depth_new;
    logic [IDX_W-1:0]   wptr_q;
    logic [IDX_W-1:0]   sel_q;
    logic               cause_q;
    logic               int_en_q;
    logic               msg_valid_q;
    logic [WORD_W-1:0]  msg_in_q;
    logic [WORD_W-1:0]  msg_out_q;

    logic wr_depth, wr_wptr, wr_cause, wr_en, wr_msg, wr_sel;

    always_comb begin
        wr_depth     = wr_i.we && (wr_i.id == REG_DEPTH);
        wr_wptr      = wr_i.we && (wr_i.id == REG_WPTR);
        wr_cause     = wr_i.we && (wr_i.id == REG_CAUSE);
        wr_en        = wr_i.we && (wr_i.id == REG_ENABLE);
        wr_msg       = wr_i.we && (wr_i.id == REG_MSG_IN);
        wr_sel       = wr_i.we && (wr_i.id == REG_UNIT_SEL);
        in_wr_addr_o = wr_i.we && (wr_i.id == REG_UNIT_ADDR);
        in_wr_size_o = wr_i.we && (wr_i.id == REG_UNIT_SIZE);
    end

    // clamp the programmed depth into 1..MAX_DEPTH
    always_comb begin
        if (wr_i.data == '0) begin
            depth_new = DEPTH_W'(1);
        end else if (wr_i.data > WORD_W'(MAX_DEPTH)) begin
            depth_new = DEPTH_MAX;
        end else begin
            depth_new = wr_i.data[DEPTH_W-1:0];
        end
    end

    assign reload_o     = wr_depth;
    assign reload_idx_o = IDX_W'(depth_new - 1'b1);
    assign last_idx_o   = IDX_W'(depth_q - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            depth_q <= DEPTH_MAX;
            wptr_q  <= IDX_LAST;
        end else if (wr_depth) begin
            depth_q <= depth_new;
            wptr_q  <= reload_idx_o;
        end else if (wr_wptr && (wr_i.data < WORD_W'(depth_q))) begin
            wptr_q  <= wr_i.data[IDX_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q    <= '0;
            int_en_q <= 1'b0;
        end else begin
            if (wr_sel) sel_q    <= wr_i.data[IDX_W-1:0];
            if (wr_en)  int_en_q <= wr_i.data[0];
        end
    end

    // completion sets the cause bit with priority over a write-1 clear
    always_ff @(posedge clk) begin
        if (rst) begin
            cause_q <= 1'b0;
        end else if (cpl_fire_i) begin
            cause_q <= 1'b1;
        end else if (wr_cause && wr_i.data[0]) begin
            cause_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            msg_valid_q <= 1'b0;
            msg_in_q    <= '0;
            msg_out_q   <= '0;
        end else begin
            if (msg_valid_q && msg_ack_i) begin
                msg_out_q <= msg_in_q;
            end
            if (wr_msg) begin
                msg_in_q    <= wr_i.data;
                msg_valid_q <= 1'b1;
            end else if (msg_ack_i) begin
                msg_valid_q <= 1'b0;
            end
        end
    end

    always_comb begin
        case (rd_id_i)
            REG_DEPTH:     rdata_o = WORD_W'(depth_q);
            REG_WPTR:      rdata_o = WORD_W'(wptr_q);
            REG_SHADOW:    rdata_o = WORD_W'(shadow_i);
            REG_CAUSE:     rdata_o = WORD_W'(cause_q);
            REG_ENABLE:    rdata_o = WORD_W'(int_en_q);
            REG_MSG_IN:    rdata_o = msg_in_q;
            REG_MSG_OUT:   rdata_o = msg_out_q;
            REG_UNIT_SEL:  rdata_o = WORD_W'(sel_q);
            REG_UNIT_ADDR: rdata_o = WORD_W'(in_unit_i.addr);
            REG_UNIT_SIZE: rdata_o = WORD_W'(in_unit_i.size);
            REG_OUT_UNIT:  rdata_o = out_unit_i;
            default:       rdata_o = '0;
        endcase
    end

    assign wptr_o      = wptr_q;
    assign sel_o       = sel_q;
    assign msg_valid_o = msg_valid_q;
    assign msg_data_o  = msg_in_q;
    assign msg_out_o   = msg_out_q;
    assign int_en_o    = int_en_q;
    assign irq_o       = cause_q & int_en_q;

endmodule

// File: rtl/rce_in_ring.sv
module rce_in_ring
    import rce_pkg::*;
#(
    parameter int MAX_DEPTH = 32,
    parameter int IDX_W     = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reload_i,
    input  logic [IDX_W-1:0]  reload_idx_i,
    input  logic [IDX_W-1:0]  last_idx_i,
    input  logic [IDX_W-1:0]  wptr_i,
    input  logic [IDX_W-1:0]  sel_i,
    input  logic              wr_addr_i,
    input  logic              wr_size_i,
    input  logic [WORD_W-1:0] wdata_i,
    output in_unit_t          sel_unit_o,
    output logic              req_valid_o,
    input  logic              req_ready_i,
    output in_unit_t          req_unit_o
);

    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(MAX_DEPTH - 1);

    in_unit_t         units [MAX_DEPTH];
    logic [IDX_W-1:0] used_q;
    logic [IDX_W-1:0] next_idx;

    always_ff @(posedge clk) begin
        if (wr_addr_i) units[sel_i].addr <= wdata_i[REQ_ADDR_W-1:0];
        if (wr_size_i) units[sel_i].size <= wdata_i[REQ_SIZE_W-1:0];
    end

    assign next_idx    = (used_q == last_idx_i) ? '0 : used_q + 1'b1;
    assign req_valid_o = (used_q != wptr_i);
    assign req_unit_o  = units[next_idx];
    assign sel_unit_o  = units[sel_i];

    always_ff @(posedge clk) begin
        if (rst) begin
            used_q <= IDX_LAST;
        end else if (reload_i) begin
            used_q <= reload_idx_i;
        end else if (req_valid_o && req_ready_i) begin
            used_q <= next_idx;
        end
    end

endmodule

// File: rtl/rce_out_ring.sv
module rce_out_ring
    import rce_pkg::*;
#(
    parameter int MAX_DEPTH = 32,
    parameter int IDX_W     = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reload_i,
    input  logic [IDX_W-1:0]  reload_idx_i,
    input  logic [IDX_W-1:0]  last_idx_i,
    input  logic [IDX_W-1:0]  sel_i,
    input  logic              cpl_valid_i,
    input  logic [WORD_W-1:0] cpl_flag_i,
    output logic              cpl_fire_o,
    output logic [IDX_W-1:0]  shadow_o,
    output logic [WORD_W-1:0] sel_unit_o
);

    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(MAX_DEPTH - 1);

    logic [WORD_W-1:0] units [MAX_DEPTH];
    logic [IDX_W-1:0]  shadow_q;
    logic [IDX_W-1:0]  next_idx;

    assign next_idx   = (shadow_q == last_idx_i) ? '0 : shadow_q + 1'b1;
    assign cpl_fire_o = cpl_valid_i && !reload_i;

    always_ff @(posedge clk) begin
        if (cpl_fire_o) units[next_idx] <= cpl_flag_i | HOST_MARK;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= IDX_LAST;
        end else if (reload_i) begin
            shadow_q <= reload_idx_i;
        end else if (cpl_fire_o) begin
            shadow_q <= next_idx;
        end
    end

    assign shadow_o   = shadow_q;
    assign sel_unit_o = units[sel_i];

endmodule

// File: rtl/ring_cpl_engine.sv
module ring_cpl_engine
    import rce_pkg::*;
#(
    parameter int MAX_DEPTH = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we_i,
    input  logic [3:0]  reg_addr_i,
    input  logic [31:0] reg_wdata_i,
    output logic [31:0] reg_rdata_o,
    output logic        req_valid_o,
    input  logic        req_ready_i,
    output logic [31:0] req_addr_o,
    output logic [15:0] req_size_o,
    input  logic        cpl_valid_i,
    input  logic [31:0] cpl_flag_i,
    output logic        msg_valid_o,
    output logic [31:0] msg_data_o,
    input  logic        msg_ack_i,
    output logic        irq_o
);

    localparam int IDX_W   = (MAX_DEPTH > 1) ? $clog2(MAX_DEPTH) : 1;
    localparam int DEPTH_W = $clog2(MAX_DEPTH + 1);

    host_wr_t          host_wr;
    logic              reload;
    logic [IDX_W-1:0]  reload_idx;
    logic [IDX_W-1:0]  last_idx;
    logic [IDX_W-1:0]  wptr;
    logic [IDX_W-1:0]  sel;
    logic              in_wr_addr;
    logic              in_wr_size;
    logic [IDX_W-1:0]  shadow;
    in_unit_t          in_sel_unit;
    in_unit_t          req_unit;
    logic [WORD_W-1:0] out_sel_unit;
    logic              cpl_fire;
    logic [WORD_W-1:0] msg_out;
    logic              int_en;

    assign host_wr.we   = reg_we_i;
    assign host_wr.id   = reg_id_e'(reg_addr_i);
    assign host_wr.data = reg_wdata_i;

    rce_host_regs #(
        .MAX_DEPTH(MAX_DEPTH), .IDX_W(IDX_W), .DEPTH_W(DEPTH_W)
    ) u_regs (
        .clk          (clk),
        .rst          (rst),
        .wr_i         (host_wr),
        .rd_id_i      (reg_id_e'(reg_addr_i)),
        .rdata_o      (reg_rdata_o),
        .reload_o     (reload),
        .reload_idx_o (reload_idx),
        .last_idx_o   (last_idx),
        .wptr_o       (wptr),
        .sel_o        (sel),
        .in_wr_addr_o (in_wr_addr),
        .in_wr_size_o (in_wr_size),
        .shadow_i     (shadow),
        .in_unit_i    (in_sel_unit),
        .out_unit_i   (out_sel_unit),
        .cpl_fire_i   (cpl_fire),
        .msg_ack_i    (msg_ack_i),
        .msg_valid_o  (msg_valid_o),
        .msg_data_o   (msg_data_o),
        .msg_out_o    (msg_out),
        .int_en_o     (int_en),
        .irq_o        (irq_o)
    );

    rce_in_ring #(.MAX_DEPTH(MAX_DEPTH), .IDX_W(IDX_W)) u_in (
        .clk          (clk),
        .rst          (rst),
        .reload_i     (reload),
        .reload_idx_i (reload_idx),
        .last_idx_i   (last_idx),
        .wptr_i       (wptr),
        .sel_i        (sel),
        .wr_addr_i    (in_wr_addr),
        .wr_size_i    (in_wr_size),
        .wdata_i      (reg_wdata_i),
        .sel_unit_o   (in_sel_unit),
        .req_valid_o  (req_valid_o),
        .req_ready_i  (req_ready_i),
        .req_unit_o   (req_unit)
    );

    rce_out_ring #(.MAX_DEPTH(MAX_DEPTH), .IDX_W(IDX_W)) u_out (
        .clk          (clk),
        .rst          (rst),
        .reload_i     (reload),
        .reload_idx_i (reload_idx),
        .last_idx_i   (last_idx),
        .sel_i        (sel),
        .cpl_valid_i  (cpl_valid_i),
        .cpl_flag_i   (cpl_flag_i),
        .cpl_fire_o   (cpl_fire),
        .shadow_o     (shadow),
        .sel_unit_o   (out_sel_unit)
    );

    assign req_addr_o = req_unit.addr;
    assign req_size_o = req_unit.size;

endmodule

// File: rtl/rce_checker.sv
module rce_checker #(
    parameter int IDX_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             host_we,
    input logic             reload,
    input logic             cpl_fire,
    input logic             int_en,
    input logic             irq,
    input logic [IDX_W-1:0] shadow,
    input logic [IDX_W-1:0] last_idx,
    input logic             req_valid,
    input logic             req_ready,
    input logic [31:0]      req_addr,
    input logic [15:0]      req_size,
    input logic             msg_valid,
    input logic             msg_ack,
    input logic [31:0]      msg_data,
    input logic [31:0]      msg_out
);

    logic rst_seen_q;

    always_ff @(posedge clk) begin
        rst_seen_q <= rst;
    end

    // R1
    always_ff @(posedge clk) begin
        if (!rst && rst_seen_q) begin
            reset_state_chk: assert (!irq && !req_valid);
        end
    end

    // R2
    reload_empty_chk: assert property (@(posedge clk) disable iff (rst)
        reload |=> !req_valid);

    // R4
    offer_hold_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_ready && !host_we |=>
            req_valid && $stable(req_addr) && $stable(req_size));

    // R5
    shadow_step_chk: assert property (@(posedge clk) disable iff (rst)
        cpl_fire |=> shadow == (($past(shadow) == $past(last_idx)) ?
                                IDX_W'(0) : IDX_W'($past(shadow) + 1'b1)));

    // R6
    cause_irq_chk: assert property (@(posedge clk) disable iff (rst)
        cpl_fire && int_en && !host_we |=> irq);

    // R7
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !int_en |-> !irq);

    // R8
    msg_done_chk: assert property (@(posedge clk) disable iff (rst)
        msg_valid && msg_ack && !host_we |=>
            !msg_valid && (msg_out == $past(msg_data)));

endmodule

bind ring_cpl_engine rce_checker #(.IDX_W(IDX_W)) u_rce_chk (
    .clk       (clk),
    .rst       (rst),
    .host_we   (reg_we_i),
    .reload    (reload),
    .cpl_fire  (cpl_fire),
    .int_en    (int_en),
    .irq       (irq_o),
    .shadow    (shadow),
    .last_idx  (last_idx),
    .req_valid (req_valid_o),
    .req_ready (req_ready_i),
    .req_addr  (req_addr_o),
    .req_size  (req_size_o),
    .msg_valid (msg_valid_o),
    .msg_ack   (msg_ack_i),
    .msg_data  (msg_data_o),
    .msg_out   (msg_out)
);

// File: tb/test_ring_cpl_engine.sv
module test_ring_cpl_engine;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        req_valid;
    logic        req_ready = 1'b0;
    logic [31:0] req_addr;
    logic [15:0] req_size;
    logic        cpl_valid = 1'b0;
    logic [31:0] cpl_flag = '0;
    logic        msg_valid;
    logic [31:0] msg_data;
    logic        msg_ack = 1'b0;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    ring_cpl_engine i_ring_cpl_engine (
        .clk(clk), .rst(rst),
        .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
        .reg_rdata_o(reg_rdata),
        .req_valid_o(req_valid), .req_ready_i(req_ready),
        .req_addr_o(req_addr), .req_size_o(req_size),
        .cpl_valid_i(cpl_valid), .cpl_flag_i(cpl_flag),
        .msg_valid_o(msg_valid), .msg_data_o(msg_data), .msg_ack_i(msg_ack),
        .irq_o(irq)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic complete(input logic [31:0] f);
        @(negedge clk);
        cpl_valid = 1'b1; cpl_flag = f;
        @(negedge clk);
        cpl_valid = 1'b0;
    endtask

    function automatic logic [31:0] exp_addr(int d, int r, int u);
        return 32'h1000_0000 + 32'(d << 12) + 32'(r << 8) + 32'(u * 4);
    endfunction

    function automatic logic [15:0] exp_size(int r, int u);
        return 16'(u * 32 + r + 1);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] held_a;
        int dl [5] = '{1, 2, 3, 5, 32};
        int pin, pout, n;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(4'd0, v); chk(v == 32, "R1 depth", v, 32);
        rd(4'd1, v); chk(v == 31, "R1 wptr", v, 31);
        rd(4'd2, v); chk(v == 31, "R1 shadow", v, 31);
        rd(4'd3, v); chk(v == 0, "R1 cause", v, 0);
        chk(!irq && !req_valid, "R1 irq/valid", {30'd0, irq, req_valid}, 0);

        // R8 message path
        wr(4'd5, 32'hCAFE_0001);
        #1 chk(msg_valid && msg_data == 32'hCAFE_0001, "R8 raise", msg_data, 32'hCAFE_0001);
        rd(4'd6, v); chk(v == 0, "R8 out before ack", v, 0);
        @(negedge clk); msg_ack = 1'b1;
        @(negedge clk); msg_ack = 1'b0;
        #1 chk(!msg_valid, "R8 drop", {31'd0, msg_valid}, 0);
        rd(4'd6, v); chk(v == 32'hCAFE_0001, "R8 echo", v, 32'hCAFE_0001);

        // R2 clamping
        wr(4'd0, 32'd0);  rd(4'd0, v); chk(v == 1, "R2 clamp low", v, 1);
        wr(4'd0, 32'd40); rd(4'd0, v); chk(v == 32, "R2 clamp high", v, 32);
        rd(4'd1, v); chk(v == 31, "R2 wptr reload", v, 31);

        wr(4'd4, 32'd1);

        // depth sweep with wrap-around rounds
        foreach (dl[i]) begin
            int d = dl[i];
            wr(4'd0, 32'(d));
            pin = d - 1; pout = d - 1;
            rd(4'd2, v); chk(v == 32'(d - 1), "R2 shadow reload", v, 32'(d - 1));
            #1 chk(!req_valid, "R2 empty after reload", {31'd0, req_valid}, 0);
            if (d == 1) begin
                wr(4'd1, 32'd0);
                #1 chk(!req_valid, "R3 depth one empty", {31'd0, req_valid}, 0);
                complete(32'h0000_0077);
                rd(4'd2, v); chk(v == 0, "R5 depth one shadow", v, 0);
                wr(4'd7, 32'd0);
                rd(4'd10, v); chk(v == 32'h4000_0077, "R5 depth one unit", v, 32'h4000_0077);
            end else begin
                for (int r = 0; r < 3; r++) begin
                    n = d - 1;
                    for (int k = 0; k < n; k++) begin
                        int u = (pin + 1 + k) % d;
                        wr(4'd7, 32'(u));
                        wr(4'd8, exp_addr(d, r, u));
                        wr(4'd9, 32'(exp_size(r, u)));
                    end
                    wr(4'd1, 32'((pin + n) % d));
                    wr(4'd1, 32'(d));
                    rd(4'd1, v);
                    chk(v == 32'((pin + n) % d), "R9 wptr out of range", v, 32'((pin + n) % d));
                    // hold while not ready
                    #1 chk(req_valid, "R4 offered", {31'd0, req_valid}, 1);
                    held_a = req_addr;
                    @(negedge clk);
                    #1 chk(req_valid && req_addr == held_a, "R4 hold", req_addr, held_a);
                    req_ready = 1'b1;
                    for (int k = 0; k < n; k++) begin
                        int u = (pin + 1 + k) % d;
                        #1 chk(req_valid && req_addr == exp_addr(d, r, u),
                               "R3 order addr", req_addr, exp_addr(d, r, u));
                        chk(req_size == exp_size(r, u), "R3 order size",
                            32'(req_size), 32'(exp_size(r, u)));
                        @(negedge clk);
                    end
                    req_ready = 1'b0;
                    #1 chk(!req_valid, "R3 drained", {31'd0, req_valid}, 0);
                    pin = (pin + n) % d;
                    for (int k = 0; k < n; k++) begin
                        int q = (pout + 1) % d;
                        logic [31:0] f = 32'h00AB_0000 | 32'(r << 8) | 32'(k);
                        complete(f);
                        rd(4'd2, v); chk(v == 32'(q), "R5 shadow", v, 32'(q));
                        wr(4'd7, 32'(q));
                        rd(4'd10, v); chk(v == (f | 32'h4000_0000), "R5 unit", v, f | 32'h4000_0000);
                        pout = q;
                    end
                end
            end
            rd(4'd3, v); chk(v == 1, "R6 cause set", v, 1);
            #1 chk(irq, "R7 irq on", {31'd0, irq}, 1);
            wr(4'd3, 32'd1);
            rd(4'd3, v); chk(v == 0, "R6 cause clear", v, 0);
            #1 chk(!irq, "R7 irq off", {31'd0, irq}, 0);
        end

        // R6 completion and clear in the same cycle
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 4'd3; reg_wdata = 32'd1;
        cpl_valid = 1'b1; cpl_flag = 32'h0000_0123;
        @(negedge clk);
        reg_we = 1'b0; cpl_valid = 1'b0;
        rd(4'd3, v); chk(v == 1, "R6 set wins over clear", v, 1);
        #1 chk(irq, "R7 irq after race", {31'd0, irq}, 1);
        wr(4'd4, 32'd0);
        #1 chk(!irq, "R7 gated by enable", {31'd0, irq}, 0);
        rd(4'd3, v); chk(v == 1, "R7 cause kept", v, 1);
        wr(4'd3, 32'd1);
        wr(4'd4, 32'd1);
        #1 chk(!irq, "R7 no irq after clear", {31'd0, irq}, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule